// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block models a single-port synchronous static RAM with 32 data bits and a parameterised depth. It is meant to sit behind a burst address generator or a cache controller. Every control, the address and the write data are captured on the rising clock edge. A write is carried out into the array one edge later from those captured values. A read goes through a second register before it reaches the pad, so read data appears after the second rising edge following the command. That gives a first access of three cycles, and each later pipelined access takes one cycle.

Writes are qualified in two tiers. A global write strobe stores all four byte lanes. Otherwise, a byte-write enable lets individual active-low lane enables choose which lanes are stored. A cycle that stores nothing is a read. Three chip enables are captured only when a new address is loaded, and a load that fails to select the part turns the slot into a no-op. The pad driver enable is the logical result of the asynchronous output enable, a pending read, and the absence of any write, so the shared bus is never driven during a write. An asynchronous sleep input freezes the array and ignores commands. The first command is honoured only on the second rising edge after sleep is released.

Top module: `sramPipe`

## Requirements
- R1: A selected read loaded at rising edge k presents the word at the loaded address on `dataOut` with `dataOutEn` high after edge k+1 (with `oeN` low). `dataOutEn` stays low between edges k and k+1 when the previous slot was not a read, and `dataOut` holds its value in cycles with no read.
- R2: With `gwN` low, a selected cycle writes all four byte lanes from `dataIn`, whatever `bweN` and `bwN` are.
- R3: With `gwN` high and `bweN` low, exactly the lanes i for which `bwN[i]` is 0 are written, where lane i is bits 8i+7..8i. Every one of the 16 combinations is valid, and lanes that are not enabled keep their old contents.
- R4: A cycle with `gwN` high and either `bweN` high or `bwN` all ones is a read, and it leaves the array unchanged.
- R5: `oeN` acts asynchronously. When it is high, `dataOutEn` is low at once. When it returns low while read data is valid, the same word is driven again.
- R6: `dataOutEn` is low whenever the write inputs present a write, and in the cycle after a write is captured, whatever the value of `oeN`.
- R7: The part is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0 at a load. A load with any enable inactive writes nothing, and `dataOutEn` falls after the one read already in the pipeline drains.
- R8: The address and the selection are captured only when `loadN` is low. When `loadN` is high, the held address and selection are used again.
- R9: While `sleep` is high, commands are ignored, the array keeps its contents and `dataOutEn` is low. A command at the first rising edge after `sleep` falls is also ignored, and the following edge accepts commands.
- R10: During and right after reset, `dataOutEn` is low and no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline state |
| addr | input | ADDR_W | Word address, captured at a load |
| loadN | input | 1 | Active-low strobe that loads a new address and chip selection |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| gwN | input | 1 | Global write, active low, stores all lanes |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Per-lane write enables, active low, bit i for bits 8i+7..8i |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request, active high |
| dataIn | input | 32 | Write data from the shared bus |
| dataOut | output | 32 | Registered read data toward the bus |
| dataOutEn | output | 1 | Pad driver enable; low means the bus is high-Z |

## Verification
The sweeps write every address through the global path while the lane enables are noisy, then cycle the lane masks through all sixteen patterns, and read back each word against a masked reference. A design that ignored the global override, or decoded the lanes in the wrong order, would return mixed bytes. Cycles that look almost like writes (lane enables low with the byte-write enable high, and the reverse) are followed by a readback, which catches a decoder that writes when it should read. The bench also aims at the bus discipline: a write arriving while read data is on the bus, the write slot itself, a deselect behind a valid read, and the edge just after sleep. A wrong driver enable would show a driven bus during a write, a pipeline that fails to drain, or a command accepted too early.

// File: rtl/sramPipePkg.sv
package sramPipePkg;
  localparam int LANE_CNT = 4;
  localparam int LANE_W   = 8;
  localparam int WORD_W   = LANE_CNT * LANE_W;

  // Strobes from control to datapath for one clock slot
  typedef struct packed {
    logic                capAddr;  // load address register
    logic                capData;  // load write data register
    logic [LANE_CNT-1:0] wrMask;   // lanes to commit this edge
    logic                rdStrobe; // fetch word into output register
    logic                driveEn;  // pad driver enable
  } sramStrobes_t;
endpackage

// File: rtl/sramPipeCtrl.sv
module sramPipeCtrl
  import sramPipePkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadN,
  input  logic                ce1N,
  input  logic                ce2,
  input  logic                ce3N,
  input  logic                gwN,
  input  logic                bweN,
  input  logic [LANE_CNT-1:0] bwN,
  input  logic                oeN,
  input  logic                sleep,
  output sramStrobes_t        strobes
);
  logic                selQ, sleepQ, s1Rd, outValidQ;
  logic [LANE_CNT-1:0] s1WrMask, wrMaskNow;
  logic                ceHit, accept, selNow, writeNow;

  // Lane decode: global write forces every lane, else per-lane under bweN
  for (genvar g = 0; g < LANE_CNT; g++) begin : gLaneDecode
    assign wrMaskNow[g] = ~gwN | (~bweN & ~bwN[g]);
  end

  assign ceHit    = ~ce1N & ce2 & ~ce3N;
  assign accept   = ~sleep & ~sleepQ;
  assign selNow   = loadN ? selQ : ceHit;
  assign writeNow = |wrMaskNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= 1'b0;
      sleepQ    <= 1'b0;
      s1Rd      <= 1'b0;
      s1WrMask  <= '0;
      outValidQ <= 1'b0;
    end else begin
      sleepQ    <= sleep;
      outValidQ <= s1Rd;
      if (accept) begin
        if (!loadN) selQ <= ceHit;
        s1Rd     <= selNow & ~writeNow;
        s1WrMask <= selNow ? wrMaskNow : '0;
      end else begin
        s1Rd     <= 1'b0;
        s1WrMask <= '0;
      end
    end
  end

  always_comb begin
    strobes.capAddr  = accept & ~loadN;
    strobes.capData  = accept;
    strobes.wrMask   = s1WrMask;
    strobes.rdStrobe = s1Rd;
    strobes.driveEn  = ~oeN & outValidQ & ~sleep & ~writeNow & ~(|s1WrMask);
  end

  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> (s1WrMask == '0 && !s1Rd));

  assert_deselect_noop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadN && (ce1N || !ce2 || ce3N)) |=> (s1WrMask == '0 && !s1Rd));

  assert_read_to_output_R1: assert property (@(posedge clk) disable iff (!rstN)
    s1Rd |=> outValidQ);

  assert_held_select_R8: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !sleep && !sleepQ && !selQ) |=> (s1WrMask == '0 && !s1Rd));
endmodule

// File: rtl/sramPipeData.sv
module sramPipeData
  import sramPipePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      dataOut <= '0;
    end else begin
      if (strobes.capAddr)  addrQ   <= addr;
      if (strobes.capData)  dataQ   <= dataIn;
      if (strobes.rdStrobe) dataOut <= mem[addrQ];
    end
  end

  // Late write: commit captured data one edge after capture
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANE_CNT; l++) begin
      if (strobes.wrMask[l]) mem[addrQ][l*LANE_W +: LANE_W] <= dataQ[l*LANE_W +: LANE_W];
    end
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLaneChk
    assert_lane_written_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrMask[g] |=> mem[$past(addrQ)][g*LANE_W +: LANE_W] == $past(dataQ[g*LANE_W +: LANE_W]));
    assert_lane_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrMask[g] |=> mem[$past(addrQ)][g*LANE_W +: LANE_W] == $past(mem[addrQ][g*LANE_W +: LANE_W]));
  end

  assert_out_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(dataOut));
endmodule

// File: rtl/sramPipe.sv
module sramPipe
  import sramPipePkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                loadN,
  input  logic                ce1N,
  input  logic                ce2,
  input  logic                ce3N,
  input  logic                gwN,
  input  logic                bweN,
  input  logic [LANE_CNT-1:0] bwN,
  input  logic                oeN,
  input  logic                sleep,
  input  logic [WORD_W-1:0]   dataIn,
  output logic [WORD_W-1:0]   dataOut,
  output logic                dataOutEn
);
  sramStrobes_t strobes;

  sramPipeCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN), .sleep(sleep), .strobes(strobes)
  );

  sramPipeData #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  assign dataOutEn = strobes.driveEn;

  assert_bus_off_global_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !gwN |-> !dataOutEn);

  assert_bus_off_output_disable_R5: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataOutEn);

  assert_bus_off_sleep_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOutEn);
endmodule

// File: tb/sramPipe_tb.sv
module sramPipe_tb;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic loadN = 1'b1, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic gwN = 1'b1, bweN = 1'b1, oeN = 1'b1, sleep = 1'b0;
  logic [3:0] bwN = 4'hF;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic dataOutEn;

  logic [31:0] refMem [DEPTH];
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sramPipe #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .loadN(loadN), .ce1N(ce1N), .ce2(ce2),
    .ce3N(ce3N), .gwN(gwN), .bweN(bweN), .bwN(bwN), .oeN(oeN), .sleep(sleep),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleCmd();  // deselecting load, non-write
    loadN = 1'b0; ce1N = 1'b0; ce2 = 1'b0; ce3N = 1'b0;
    gwN = 1'b1; bweN = 1'b1; bwN = 4'hF; oeN = 1'b0;
  endtask

  task automatic selCmd(input logic [AW-1:0] a);
    loadN = 1'b0; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0; addr = a;
  endtask

  function automatic logic [31:0] patA(input int a);
    logic [7:0] b = 8'(a);
    return {b, ~b, b ^ 8'h3C, b + 8'h11};
  endfunction

  function automatic logic [31:0] patB(input int a);
    logic [7:0] b = 8'(a);
    return {b ^ 8'hC3, b + 8'h77, ~(b ^ 8'h5A), b + 8'h01};
  endfunction

  // Selected write with given qualifiers; checks bus stays off in the write slot (R6)
  task automatic writeCmd(input logic [AW-1:0] a, input logic [31:0] d,
                          input logic g, input logic be, input logic [3:0] bw);
    selCmd(a); gwN = g; bweN = be; bwN = bw; dataIn = d; oeN = 1'b0;
    tick();
    idleCmd();
    #1;
    chk(!dataOutEn, "R6 write slot bus off", {31'd0, dataOutEn}, 32'd0);
    tick();
    if (!g) refMem[a] = d;
    else if (!be) for (int l = 0; l < 4; l++) if (!bw[l]) refMem[a][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic readChk(input logic [AW-1:0] a, input string req);
    selCmd(a); gwN = 1'b1; bweN = 1'b1; bwN = 4'hF; oeN = 1'b0;
    tick();
    idleCmd();
    tick();
    chk(dataOutEn === 1'b1 && dataOut === refMem[a], req, dataOut, refMem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    oeN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dataOutEn, "R10 bus off in reset", {31'd0, dataOutEn}, 32'd0);
    rstN = 1'b1;
    idleCmd();
    tick();
    chk(!dataOutEn, "R10 bus off after reset", {31'd0, dataOutEn}, 32'd0);

    // R2: global write sweep, lane enables noisy
    for (int a = 0; a < DEPTH; a++) writeCmd(AW'(a), patA(a), 1'b0, a[0], 4'(a));
    for (int a = 0; a < DEPTH; a++) readChk(AW'(a), "R2 global write readback");

    // R3: lane mask sweep, all 16 patterns
    for (int a = 0; a < DEPTH; a++) writeCmd(AW'(a), patB(a), 1'b1, 1'b0, 4'(a));
    for (int a = 0; a < DEPTH; a++) readChk(AW'(a), "R3 lane write readback");

    // R4: near-write cycles are reads and store nothing
    for (int a = 0; a < 32; a++) begin
      selCmd(AW'(a)); gwN = 1'b1; dataIn = 32'hDEAD_BEEF;
      bweN = a[0]; bwN = a[0] ? 4'h0 : 4'hF;
      tick();
      idleCmd();
      tick();
      chk(dataOutEn === 1'b1 && dataOut === refMem[a], "R4 non-write cycle reads", dataOut, refMem[a]);
    end
    for (int a = 0; a < 32; a++) readChk(AW'(a), "R4 array unchanged");

    // R1: latency, first slot off then data
    idleCmd(); tick();
    selCmd(8'd40); gwN = 1'b1; bweN = 1'b1; bwN = 4'hF;
    tick();
    idleCmd();
    #1;
    chk(!dataOutEn, "R1 no data before second edge", {31'd0, dataOutEn}, 32'd0);
    tick();
    chk(dataOutEn && dataOut === refMem[40], "R1 data after second edge", dataOut, refMem[40]);

    // R5: asynchronous output enable (data held: slot after idle has no read)
    selCmd(8'd41); tick();
    idleCmd(); tick();
    oeN = 1'b1; #1;
    chk(!dataOutEn, "R5 oeN high bus off", {31'd0, dataOutEn}, 32'd0);
    oeN = 1'b0; #1;
    chk(dataOutEn && dataOut === refMem[41], "R5 oeN low redrive", dataOut, refMem[41]);
    tick();
    chk(!dataOutEn && dataOut === refMem[41], "R1 output held without read", dataOut, refMem[41]);

    // R6: write inputs arriving while read data is on the bus
    selCmd(8'd42); tick();
    idleCmd(); tick();
    chk(dataOutEn === 1'b1, "R6 read valid before write", {31'd0, dataOutEn}, 32'd1);
    gwN = 1'b0; #1;
    chk(!dataOutEn, "R6 write input forces bus off", {31'd0, dataOutEn}, 32'd0);
    gwN = 1'b1; bweN = 1'b0; bwN = 4'b1011; #1;
    chk(!dataOutEn, "R6 lane write forces bus off", {31'd0, dataOutEn}, 32'd0);
    idleCmd(); tick();

    // R7: each inactive enable blocks a write
    for (int k = 0; k < 3; k++) begin
      selCmd(8'd7); gwN = 1'b0; dataIn = 32'h1234_5600 + 32'(k);
      if (k == 0) ce1N = 1'b1; else if (k == 1) ce2 = 1'b0; else ce3N = 1'b1;
      tick();
      idleCmd(); tick();
      readChk(8'd7, "R7 deselected write ignored");
    end
    // R7: deselect behind a read drains then goes off
    selCmd(8'd7); tick();
    selCmd(8'd8); ce1N = 1'b1; tick();
    chk(dataOutEn && dataOut === refMem[7], "R7 pending read completes", dataOut, refMem[7]);
    tick();
    chk(!dataOutEn, "R7 bus off after drain", {31'd0, dataOutEn}, 32'd0);

    // R8: held address used when loadN high
    writeCmd(8'd9, 32'hAAAA_0001, 1'b0, 1'b1, 4'hF);
    selCmd(8'd9); gwN = 1'b0; dataIn = 32'h5555_0002; tick();
    loadN = 1'b1; addr = 8'd10; ce2 = 1'b0; dataIn = 32'h6666_0003; tick();
    idleCmd(); tick();
    refMem[9] = 32'h6666_0003;
    readChk(8'd9, "R8 held address written");
    readChk(8'd10, "R8 new address not loaded");

    // R9: sleep
    idleCmd(); tick();
    sleep = 1'b1; #1;
    chk(!dataOutEn, "R9 bus off in sleep", {31'd0, dataOutEn}, 32'd0);
    selCmd(8'd5); gwN = 1'b0; dataIn = 32'hFFFF_0000; tick(); tick();
    sleep = 1'b0; dataIn = 32'hEEEE_0000; tick();
    idleCmd(); tick();
    readChk(8'd5, "R9 commands ignored in and just after sleep");
    writeCmd(8'd5, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    readChk(8'd5, "R9 command accepted afterwards");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule